// File: doc/BRIEF.md
# Serial Port Interrupt and Modem Status Controller

This block is the interrupt side of a classic byte-wide serial port controller. It holds the interrupt enable, FIFO control and modem control bits. It tracks the four modem handshake lines and notes when each of them changes. It compares the receive FIFO fill level against a selectable threshold. From these sources it chooses one pending cause, reports it as a four-bit identification code, and drives a single interrupt request line.

Software reaches the block through a small register port. Reads have side effects: reading the modem status clears its change flags, and reading the identification register retires a transmitter-empty cause when that cause is the one shown. The shifters, baud generation and FIFO storage sit outside the block. The block only receives their fill level, error flags, timeout pulse and holding-empty flag.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the interrupt line is low. The enable, modem-control and modem-status change bits read 0. The identification register reads 0x01 while no source is pending.
- R2: The identification code in bits [3:0] reports the highest enabled pending cause, in this priority order: line error 0x6 (any `line_err` bit set, enable bit 2), then receive data 0x4 (enable bit 0), then receive timeout 0xC (enable bit 0), then transmitter empty 0x2 (enable bit 1), then modem change 0x0 (any change bit set, enable bit 3). When none is pending the code is 0x1.
- R3: Identification bits [7:6] read 2'b11 when FIFO mode is on (FIFO-control write bit 0) and 2'b00 otherwise. Bits [5:4] read 0.
- R4: Receive data is pending when the fill level is at least the threshold chosen by FIFO-control bits [7:6]: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 14. With FIFO mode off, any nonzero level counts.
- R5: Modem status bits [7:4] show DCD, RI, DSR and CTS (inputs `modem_in[3:0]` in that order, bit 3 = DCD). Each line passes through a two-stage synchroniser, so a change at the pins appears two clocks later.
- R6: Change bits 3, 1 and 0 of the modem status set on any change of the synchronised DCD, DSR or CTS. Bit 2 sets only on a low-to-high RI transition.
- R7: A modem status read returns the change bits and clears all four of them. A change detected in the same cycle as the read is kept.
- R8: The transmitter-empty cause sets on a rising edge of `thr_empty`. It clears on a write to the holding address, or on an identification read while code 0x2 is shown. An identification read showing any other code leaves it pending. Clearing wins over setting.
- R9: A `rx_timeout` pulse latches a timeout cause while the fill level is nonzero. The cause clears whenever the fill level is 0.
- R10: `irq` is high only when modem-control bit 3 is set and some enabled cause is pending.
- R11: Register addresses: 0 interrupt enable (bits [3:0], read back with upper bits 0); 1 identification on read and FIFO control on write; 2 modem control (8 bits, read back); 3 modem status; 4 holding-register write strobe. `bus_rdata` is 0 when not reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects apply at the clock edge) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle `bus_rd` is high |
| modem_in | input | 4 | Raw handshake lines {DCD, RI, DSR, CTS}, asynchronous |
| rx_level | input | LVL_W | Receive FIFO fill level |
| line_err | input | 4 | Receive error flags (overrun, parity, framing, break) |
| rx_timeout | input | 1 | One-cycle receive timeout pulse |
| thr_empty | input | 1 | Transmit holding register empty |
| irq | output | 1 | Interrupt request |

## Verification
The bench reads modem status at every offset around a line change, including the exact cycle the change is detected. A design that cleared change bits without keeping the arriving change would lose that event. The bench drops RI and expects no ring flag, which catches a block that flags both edges. It sweeps the fill level through every threshold setting, which exposes any off-by-one in the compare. It also retires sources one at a time while others remain pending. This shows whether priority is wrong, or whether an identification read retires the transmitter cause while a different code is shown.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_IEN  = 3'd0,
      A_IID  = 3'd1,
      A_MCTL = 3'd2,
      A_MSTS = 3'd3,
      A_HOLD = 3'd4
   } reg_addr_e;

   typedef enum logic [3:0] {
      ID_MODEM   = 4'h0,
      ID_NONE    = 4'h1,
      ID_TXEMPTY = 4'h2,
      ID_RXDATA  = 4'h4,
      ID_LINE    = 4'h6,
      ID_TIMEOUT = 4'hC
   } irq_id_e;

   // pending-source vector positions, highest priority at top
   localparam int SRC_N    = 5;
   localparam int SRC_LINE = 4;
   localparam int SRC_RX   = 3;
   localparam int SRC_TO   = 2;
   localparam int SRC_TX   = 1;
   localparam int SRC_MDM  = 0;

   localparam int N_TRIG = 4;

   function automatic int trig_of(input int sel);
      case (sel)
         0:       return 1;
         1:       return 4;
         2:       return 8;
         default: return 14;
      endcase
   endfunction

endpackage

// File: rtl/uart_msr_track.sv
module uart_msr_track #(
   parameter int N_LINES     = 4,
   parameter int SYNC_STAGES = 2,
   parameter logic [N_LINES-1:0] RISE_ONLY = 4'b0100
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] lines_in,
   input  logic               rd_clear,
   output logic [N_LINES-1:0] level,
   output logic [N_LINES-1:0] delta
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("uart_msr_track: SYNC_STAGES must be at least 2");
   end

   logic [N_LINES-1:0] prev_q;
   logic [N_LINES-1:0] change;
   logic [N_LINES-1:0] delta_q;

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      logic [SYNC_STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_q      <= '0;
            prev_q[i] <= 1'b0;
         end else begin
            sh_q      <= {sh_q[SYNC_STAGES-2:0], lines_in[i]};
            prev_q[i] <= sh_q[SYNC_STAGES-1];
         end
      end
      assign level[i] = sh_q[SYNC_STAGES-1];
      if (RISE_ONLY[i]) begin : g_rise
         assign change[i] = level[i] & ~prev_q[i];
      end else begin : g_any
         assign change[i] = level[i] ^ prev_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) delta_q <= '0;
      else        delta_q <= (rd_clear ? '0 : delta_q) | change;
   end

   assign delta = delta_q;

   AST_DELTA_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clear |=> ((delta_q & ~$past(change)) == '0)); // R7

   AST_RI_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(delta_q[2]) |-> prev_q[2]); // R6

endmodule

// File: rtl/uart_rx_trigger.sv
module uart_rx_trigger
   import uart_irq_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic [LVL_W-1:0] level,
   input  logic             fifo_en,
   input  logic [1:0]       sel,
   output logic             reached
);

   if (FIFO_DEPTH < trig_of(N_TRIG - 1)) begin : g_bad_depth
      $error("uart_rx_trigger: FIFO_DEPTH below largest threshold");
   end

   logic [N_TRIG-1:0] hit;

   for (genvar t = 0; t < N_TRIG; t++) begin : g_thr
      assign hit[t] = (level >= LVL_W'(trig_of(t)));
   end

   assign reached = fifo_en ? hit[sel] : (level != '0);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_N-1:0] pend,
   output irq_id_e          code
);

   always_comb begin
      if      (pend[SRC_LINE]) code = ID_LINE;
      else if (pend[SRC_RX])   code = ID_RXDATA;
      else if (pend[SRC_TO])   code = ID_TIMEOUT;
      else if (pend[SRC_TX])   code = ID_TXEMPTY;
      else if (pend[SRC_MDM])  code = ID_MODEM;
      else                     code = ID_NONE;
   end

   AST_ID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |-> (code == ID_NONE)); // R2

   AST_ID_LINE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      pend[SRC_LINE] |-> (code == ID_LINE)); // R2

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int FIFO_DEPTH  = 16,
   parameter int SYNC_STAGES = 2,
   localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [3:0]        modem_in,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic [3:0]        line_err,
   input  logic              rx_timeout,
   input  logic              thr_empty,
   output logic              irq
);

   logic [3:0]       ien_q;
   logic [7:0]       mctl_q;
   logic             fifo_en_q;
   logic [1:0]       trig_sel_q;
   logic             thr_prev_q;
   logic             tx_pend_q;
   logic             to_pend_q;
   logic             rx_hit;
   logic [3:0]       m_level;
   logic [3:0]       m_delta;
   logic [SRC_N-1:0] pend;
   irq_id_e          code;

   wire wr_ien  = bus_wr && (bus_addr == A_IEN);
   wire wr_fctl = bus_wr && (bus_addr == A_IID);
   wire wr_mctl = bus_wr && (bus_addr == A_MCTL);
   wire wr_hold = bus_wr && (bus_addr == A_HOLD);
   wire rd_iid  = bus_rd && (bus_addr == A_IID);
   wire rd_msts = bus_rd && (bus_addr == A_MSTS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q      <= '0;
         mctl_q     <= '0;
         fifo_en_q  <= 1'b0;
         trig_sel_q <= '0;
      end else begin
         if (wr_ien)  ien_q  <= bus_wdata[3:0];
         if (wr_mctl) mctl_q <= bus_wdata;
         if (wr_fctl) begin
            fifo_en_q  <= bus_wdata[0];
            trig_sel_q <= bus_wdata[7:6];
         end
      end
   end

   uart_msr_track #(
      .N_LINES     (4),
      .SYNC_STAGES (SYNC_STAGES),
      .RISE_ONLY   (4'b0100)
   ) u_msr (
      .clk      (clk),
      .rst_n    (rst_n),
      .lines_in (modem_in),
      .rd_clear (rd_msts),
      .level    (m_level),
      .delta    (m_delta)
   );

   uart_rx_trigger #(
      .FIFO_DEPTH (FIFO_DEPTH),
      .LVL_W      (LVL_W)
   ) u_trig (
      .level   (rx_level),
      .fifo_en (fifo_en_q),
      .sel     (trig_sel_q),
      .reached (rx_hit)
   );

   // transmitter-empty cause: set on rising holding-empty, clear wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_prev_q <= 1'b0;
         tx_pend_q  <= 1'b0;
      end else begin
         thr_prev_q <= thr_empty;
         if (wr_hold || (rd_iid && code == ID_TXEMPTY)) tx_pend_q <= 1'b0;
         else if (thr_empty && !thr_prev_q)             tx_pend_q <= 1'b1;
      end
   end

   // receive timeout cause: held until the FIFO drains
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               to_pend_q <= 1'b0;
      else if (rx_level == '0)  to_pend_q <= 1'b0;
      else if (rx_timeout)      to_pend_q <= 1'b1;
   end

   assign pend[SRC_LINE] = ien_q[2] && (line_err != '0);
   assign pend[SRC_RX]   = ien_q[0] && rx_hit;
   assign pend[SRC_TO]   = ien_q[0] && to_pend_q;
   assign pend[SRC_TX]   = ien_q[1] && tx_pend_q;
   assign pend[SRC_MDM]  = ien_q[3] && (m_delta != '0);

   uart_irq_prio u_prio (
      .clk   (clk),
      .rst_n (rst_n),
      .pend  (pend),
      .code  (code)
   );

   assign irq = mctl_q[3] && (code != ID_NONE);

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (bus_addr)
            A_IEN:   bus_rdata = {4'b0, ien_q};
            A_IID:   bus_rdata = {{2{fifo_en_q}}, 2'b00, code};
            A_MCTL:  bus_rdata = mctl_q;
            A_MSTS:  bus_rdata = {m_level, m_delta};
            default: bus_rdata = '0;
         endcase
      end
   end

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !mctl_q[3] |-> !irq); // R10

   AST_HOLD_CLEARS_TX: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hold |=> !tx_pend_q); // R8

   AST_TO_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level == '0) |=> !to_pend_q); // R9

   AST_LINE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q[2] && line_err != '0 && rd_iid) |-> (bus_rdata[3:0] == 4'h6)); // R2

endmodule

// File: tb/uart_irq_ctrl_tb.sv
`timescale 1ns/1ps
module uart_irq_ctrl_tb;

   localparam int LVL_W = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bus_wr = 1'b0;
   logic             bus_rd = 1'b0;
   logic [2:0]       bus_addr = '0;
   logic [7:0]       bus_wdata = '0;
   logic [7:0]       bus_rdata;
   logic [3:0]       modem_in = '0;
   logic [LVL_W-1:0] rx_level = '0;
   logic [3:0]       line_err = '0;
   logic             rx_timeout = 1'b0;
   logic             thr_empty = 1'b0;
   logic             irq;

   always #2.5 clk = ~clk;

   uart_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .modem_in(modem_in), .rx_level(rx_level), .line_err(line_err),
      .rx_timeout(rx_timeout), .thr_empty(thr_empty), .irq(irq)
   );

   int    total = 0;
   int    bad = 0;
   bit    done = 0;
   string tag = "R1";

   // behavioural reference state
   logic [3:0] m_ien, m_d, s0, s1, s2;
   logic [7:0] m_mctl;
   logic       m_fen, m_thrp, m_tx, m_to;
   logic [1:0] m_sel;

   function automatic int thr_level(input logic [1:0] s);
      int t[4] = '{1, 4, 8, 14};
      return t[s];
   endfunction

   function automatic logic [3:0] ref_code();
      logic rxr;
      rxr = m_fen ? (int'(rx_level) >= thr_level(m_sel)) : (rx_level != 0);
      if (m_ien[2] && line_err != 0) return 4'h6;
      if (m_ien[0] && rxr)           return 4'h4;
      if (m_ien[0] && m_to)          return 4'hC;
      if (m_ien[1] && m_tx)          return 4'h2;
      if (m_ien[3] && m_d != 0)      return 4'h0;
      return 4'h1;
   endfunction

   always @(negedge clk) begin
      if (!rst_n) begin
         m_ien = 0; m_d = 0; s0 = 0; s1 = 0; s2 = 0; m_mctl = 0;
         m_fen = 0; m_thrp = 0; m_tx = 0; m_to = 0; m_sel = 0;
      end else if (!done) begin
         logic [3:0] c, chg;
         logic [7:0] er;
         logic       ei;
         c  = ref_code();
         ei = m_mctl[3] && (c != 4'h1);
         total++;
         if (irq !== ei) begin
            bad++;
            $display("FAIL %s irq got %0b exp %0b", tag, irq, ei);
         end
         if (bus_rd) begin
            case (bus_addr)
               3'd0:    er = {4'b0, m_ien};
               3'd1:    er = {{2{m_fen}}, 2'b00, c};
               3'd2:    er = m_mctl;
               3'd3:    er = {s1, m_d};
               default: er = 8'h00;
            endcase
            total++;
            if (bus_rdata !== er) begin
               bad++;
               $display("FAIL %s rdata addr %0d got %02h exp %02h",
                        tag, bus_addr, bus_rdata, er);
            end
         end
         // advance reference to the next clock edge
         chg = (s1 ^ s2) & 4'b1011;
         chg[2] = s1[2] & ~s2[2];
         m_d = ((bus_rd && bus_addr == 3'd3) ? 4'b0 : m_d) | chg;
         s2 = s1; s1 = s0; s0 = modem_in;
         if ((bus_wr && bus_addr == 3'd4) || (bus_rd && bus_addr == 3'd1 && c == 4'h2))
            m_tx = 0;
         else if (thr_empty && !m_thrp)
            m_tx = 1;
         m_thrp = thr_empty;
         if (rx_level == 0) m_to = 0;
         else if (rx_timeout) m_to = 1;
         if (bus_wr && bus_addr == 3'd0) m_ien = bus_wdata[3:0];
         if (bus_wr && bus_addr == 3'd2) m_mctl = bus_wdata;
         if (bus_wr && bus_addr == 3'd1) begin
            m_fen = bus_wdata[0];
            m_sel = bus_wdata[7:6];
         end
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      step(1);
      bus_wr = 0;
   endtask

   task automatic rd(input logic [2:0] a);
      bus_rd = 1; bus_addr = a;
      step(1);
      bus_rd = 0;
   endtask

   initial begin
      step(3);
      rst_n = 1;
      // reset state
      tag = "R1";
      rd(0); rd(1); rd(2); rd(3); step(1);
      // register map
      tag = "R11";
      wr(0, 8'hFF); rd(0); wr(2, 8'h0B); rd(2); rd(5);
      // synchronised levels
      tag = "R5";
      modem_in = 4'b1010; step(1); rd(3); rd(3); step(2); rd(3);
      modem_in = 4'b0101; step(1); rd(3); step(3); rd(3);
      // change detection, RI rising only
      tag = "R6";
      modem_in = 4'b0000; step(4); rd(3);
      modem_in = 4'b0100; step(4); rd(3);
      modem_in = 4'b0000; step(4); rd(3); rd(3);
      // read racing a new change
      tag = "R7";
      for (int off = 0; off < 5; off++) begin
         modem_in = modem_in ^ 4'b1111;
         step(off); rd(3); step(4); rd(3);
      end
      // thresholds
      tag = "R4";
      wr(0, 8'h01);
      for (int s = 0; s < 4; s++) begin
         wr(1, {s[1:0], 6'b000001});
         for (int l = 0; l <= 16; l++) begin
            rx_level = l[LVL_W-1:0]; step(1);
         end
         rd(1);
      end
      wr(1, 8'hC0);
      for (int l = 0; l < 3; l++) begin
         rx_level = l[LVL_W-1:0]; step(1); rd(1);
      end
      rx_level = 0;
      // FIFO-mode bits
      tag = "R3";
      wr(1, 8'h01); rd(1); wr(1, 8'h00); rd(1);
      // timeout cause
      tag = "R9";
      wr(1, 8'hC1); rx_level = 3; step(1);
      rx_timeout = 1; step(1); rx_timeout = 0; step(2); rd(1);
      rx_level = 0; step(2); rd(1);
      rx_timeout = 1; step(1); rx_timeout = 0; step(1); rd(1);
      // transmitter cause
      tag = "R8";
      wr(0, 8'h02); thr_empty = 1; step(2); rd(1); rd(1);
      thr_empty = 0; step(1); thr_empty = 1; step(2); wr(4, 8'h5A); rd(1);
      thr_empty = 0; step(1); thr_empty = 1; step(2);
      wr(0, 8'h06); line_err = 4'b0100; rd(1); line_err = 0; rd(1); rd(1);
      // priority walk
      tag = "R2";
      wr(0, 8'h0F); wr(1, 8'hC1);
      thr_empty = 0; step(1); thr_empty = 1;
      modem_in = modem_in ^ 4'b0001; rx_level = 15; line_err = 4'b0001;
      rx_timeout = 1; step(1); rx_timeout = 0; step(3);
      rd(1); line_err = 0; rd(1); rx_level = 2; rd(1);
      rx_level = 0; step(1); rd(1); rd(1); rd(3); rd(1);
      // output gate
      tag = "R10";
      thr_empty = 0; step(1); thr_empty = 1; step(2);
      wr(2, 8'h00); step(2); rd(1); step(1);
      thr_empty = 0; step(1); thr_empty = 1; step(2);
      wr(2, 8'h08); step(2); wr(0, 8'h00); step(2);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 20000; i++) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired before stimulus end");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule